// File: doc/BRIEF.md
# Pseudo-PHY Register Window Bridge

This block sits on the target side of a management register port and answers at a single device address. Software sees a small window of 16-bit registers there. One selects a page and carries an enable flag. One takes a register offset and a command. Four data registers together hold one 64-bit value. The bridge turns each command into one access on an internal paged register bus and reports progress through the command bits.

To write an internal register, software first loads the data registers. It then writes the offset together with the write command bit. It polls the command register until the command bits read zero. A read works the same way with the read command bit. Once the bits have cleared, the data registers hold the internal value. The management port is a parallel request/acknowledge interface. Serial framing is done elsewhere.

Top module: `phy_window_bridge`

## Requirements
- R1: The bridge samples a management request (`mgmt_req_i` high) at a clock edge. If `mgmt_dev_i` equals `DEV_ADDR`, then `mgmt_ack_o` is high in the following cycle, and for a read `mgmt_rdata_o` carries the register value in that cycle. A request at any other device address gets no acknowledge, changes no state, and leaves `mgmt_rdata_o` at zero.
- R2: Window offset 0x10 is the page register. Bits 15:8 hold the page number and bit 0 holds the enable flag. The other bits read as zero, and both fields reset to zero.
- R3: Window offset 0x11 is the command register. Bits 15:8 hold the target offset, bit 0 requests a write, and bit 1 requests a read. When a command launches, its bit reads back as one while the access is pending and reads zero once it has finished. The offset field reads back what was last accepted.
- R4: Window offsets 0x18, 0x19, 0x1A and 0x1B hold bits 15:0, 31:16, 47:32 and 63:48 of the 64-bit data value. They are readable and writable and reset to zero.
- R5: A write command issues exactly one internal write. The write carries the page that was enabled at launch, the offset from the command, and the data registers as `ib_wdata_o`. The strobe is held until `ib_ready_i` is sampled high and drops in the next cycle.
- R6: A read command issues exactly one internal read. At the edge where `ib_ready_i` is sampled high, the data registers load `ib_rdata_i` and the command bits clear.
- R7: While the page enable flag is zero, a command write issues no internal access and its command bits read back as zero.
- R8: A command write with both bits 0 and 1 set is carried out as a read.
- R9: Management reads of any window offset other than 0x10, 0x11 and 0x18 to 0x1B return zero, and writes to them change nothing.
- R10: A write to offset 0x11 while a command is pending is ignored, both its offset and its command bits.
- R11: The internal read and write strobes are never high together, and the page and offset outputs stay stable while a strobe waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_req_i | input | 1 | Management request, one cycle per access |
| mgmt_we_i | input | 1 | 1 = write, 0 = read |
| mgmt_dev_i | input | DEV_W | Device address of the request |
| mgmt_reg_i | input | 5 | Window register offset |
| mgmt_wdata_i | input | REG_W | Management write data |
| mgmt_ack_o | output | 1 | Access claimed, one cycle after the request |
| mgmt_rdata_o | output | REG_W | Read data, valid with the acknowledge |
| ib_page_o | output | PAGE_W | Internal bus page |
| ib_offset_o | output | OFS_W | Internal bus register offset |
| ib_rd_o | output | 1 | Internal read strobe, held until ready |
| ib_wr_o | output | 1 | Internal write strobe, held until ready |
| ib_wdata_o | output | LANES*REG_W | Internal write data (the data registers) |
| ib_rdata_i | input | LANES*REG_W | Internal read data, taken when ready |
| ib_ready_i | input | 1 | Internal access complete |

## Verification
The assertions assume that the internal responder raises `ib_ready_i` only while a strobe is high, and lowers it again right after the completing edge. The bench responder is driven at the falling edge. It answers only a visible strobe, after a chosen latency of zero to six cycles, and it pulses ready for exactly one cycle. The management stimulus issues one-cycle requests separated by an idle cycle, so no request overlaps an acknowledge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_PAGE  = 5'h10;
  localparam logic [REG_AW-1:0] OFF_CMD   = 5'h11;
  localparam logic [REG_AW-1:0] OFF_DATA0 = 5'h18;
  localparam int unsigned PAGE_EN_BIT = 0;
  localparam int unsigned CMD_WR_BIT  = 0;
  localparam int unsigned CMD_RD_BIT  = 1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WR   = 2'd1,
    SEQ_RD   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pwb_port_decode.sv
module pwb_port_decode
  import pwb_pkg::*;
#(
  parameter int unsigned DEV_W = 5,
  parameter logic [DEV_W-1:0] DEV_ADDR = 5'd30,
  parameter int unsigned LANES = 4,
  parameter int unsigned REG_W = 16,
  localparam int unsigned DATA_W = LANES * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [REG_W-1:0]  page_q_i,
  input  logic [REG_W-1:0]  cmd_q_i,
  input  logic [DATA_W-1:0] lanes_q_i,
  output logic              page_we_o,
  output logic              cmd_we_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              ack_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic             hit, is_page, is_cmd;
  logic [LANES-1:0] lane_sel;
  logic [REG_W-1:0] rd_mux;

  assign hit     = req_i && (dev_i == DEV_ADDR);
  assign is_page = (reg_i == OFF_PAGE);
  assign is_cmd  = (reg_i == OFF_CMD);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_sel
    localparam logic [REG_AW-1:0] LaneOff = REG_AW'(int'(OFF_DATA0) + l);
    assign lane_sel[l] = (reg_i == LaneOff);
  end

  assign page_we_o = hit && we_i && is_page;
  assign cmd_we_o  = hit && we_i && is_cmd;
  assign lane_we_o = {LANES{hit && we_i}} & lane_sel;

  always_comb begin
    rd_mux = '0;
    if (is_page) rd_mux = page_q_i;
    if (is_cmd)  rd_mux = cmd_q_i;
    for (int l = 0; l < LANES; l++) begin
      if (lane_sel[l]) rd_mux = lanes_q_i[l*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= hit;
      rdata_o <= (hit && !we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pwb_data_lanes.sv
module pwb_data_lanes #(
  parameter int unsigned LANES = 4,
  parameter int unsigned REG_W = 16,
  localparam int unsigned DATA_W = LANES * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] lanes_q_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [REG_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lane_q <= '0;
      else if (load_i)       lane_q <= load_data_i[l*REG_W +: REG_W];
      else if (lane_we_i[l]) lane_q <= wdata_i;
    end
    assign lanes_q_o[l*REG_W +: REG_W] = lane_q;
  end
endmodule

// File: rtl/pwb_cmd_seq.sv
module pwb_cmd_seq
  import pwb_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8,
  localparam int unsigned PAGE_PAD = REG_W - PAGE_W - 1,
  localparam int unsigned CMD_PAD  = REG_W - OFS_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_we_i,
  input  logic              cmd_we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              ib_ready_i,
  output logic [REG_W-1:0]  page_q_o,
  output logic [REG_W-1:0]  cmd_q_o,
  output logic [PAGE_W-1:0] ib_page_o,
  output logic [OFS_W-1:0]  ib_offset_o,
  output logic              ib_rd_o,
  output logic              ib_wr_o,
  output logic              load_o
);
  seq_state_e        state_q;
  logic [PAGE_W-1:0] page_num_q, ib_page_q;
  logic              page_en_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              idle, cmd_rd, cmd_wr, launch, finish;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign idle   = (state_q == SEQ_IDLE);
  assign cmd_rd = wdata_i[CMD_RD_BIT];
  assign cmd_wr = wdata_i[CMD_WR_BIT];
  assign launch = cmd_we_i && idle && page_en_q && (cmd_rd || cmd_wr);
  assign finish = !idle && ib_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_num_q <= '0;
      page_en_q  <= 1'b0;
    end else if (page_we_i) begin
      page_num_q <= wdata_i[REG_W-1 -: PAGE_W];
      page_en_q  <= wdata_i[PAGE_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      ofs_q     <= '0;
      ib_page_q <= '0;
    end else begin
      if (cmd_we_i && idle) ofs_q <= wdata_i[REG_W-1 -: OFS_W];
      if (launch) begin
        state_q   <= cmd_rd ? SEQ_RD : SEQ_WR;  // both bits: read
        ib_page_q <= page_num_q;
      end else if (finish) begin
        state_q <= SEQ_IDLE;
      end
    end
  end

  assign ib_rd_o     = (state_q == SEQ_RD);
  assign ib_wr_o     = (state_q == SEQ_WR);
  assign ib_page_o   = ib_page_q;
  assign ib_offset_o = ofs_q;
  assign load_o      = ib_rd_o && ib_ready_i;
  assign page_q_o    = {page_num_q, {PAGE_PAD{1'b0}}, page_en_q};
  assign cmd_q_o     = {ofs_q, {CMD_PAD{1'b0}}, ib_rd_o, ib_wr_o};
endmodule

// File: rtl/phy_window_bridge.sv
module phy_window_bridge
  import pwb_pkg::*;
#(
  parameter int unsigned DEV_W = 5,
  parameter logic [DEV_W-1:0] DEV_ADDR = 5'd30,
  parameter int unsigned LANES  = 4,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8,
  localparam int unsigned DATA_W = LANES * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_req_i,
  input  logic              mgmt_we_i,
  input  logic [DEV_W-1:0]  mgmt_dev_i,
  input  logic [REG_AW-1:0] mgmt_reg_i,
  input  logic [REG_W-1:0]  mgmt_wdata_i,
  output logic              mgmt_ack_o,
  output logic [REG_W-1:0]  mgmt_rdata_o,
  output logic [PAGE_W-1:0] ib_page_o,
  output logic [OFS_W-1:0]  ib_offset_o,
  output logic              ib_rd_o,
  output logic              ib_wr_o,
  output logic [DATA_W-1:0] ib_wdata_o,
  input  logic [DATA_W-1:0] ib_rdata_i,
  input  logic              ib_ready_i
);
  logic              page_we, cmd_we, load;
  logic [LANES-1:0]  lane_we;
  logic [REG_W-1:0]  page_q, cmd_q;
  logic [DATA_W-1:0] lanes_q;

  pwb_port_decode #(
    .DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR), .LANES(LANES), .REG_W(REG_W)
  ) i_decode (
    .clk_i, .rst_ni,
    .req_i(mgmt_req_i), .we_i(mgmt_we_i), .dev_i(mgmt_dev_i), .reg_i(mgmt_reg_i),
    .page_q_i(page_q), .cmd_q_i(cmd_q), .lanes_q_i(lanes_q),
    .page_we_o(page_we), .cmd_we_o(cmd_we), .lane_we_o(lane_we),
    .ack_o(mgmt_ack_o), .rdata_o(mgmt_rdata_o)
  );

  pwb_data_lanes #(.LANES(LANES), .REG_W(REG_W)) i_lanes (
    .clk_i, .rst_ni,
    .lane_we_i(lane_we), .wdata_i(mgmt_wdata_i),
    .load_i(load), .load_data_i(ib_rdata_i),
    .lanes_q_o(lanes_q)
  );

  pwb_cmd_seq #(.REG_W(REG_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_seq (
    .clk_i, .rst_ni,
    .page_we_i(page_we), .cmd_we_i(cmd_we), .wdata_i(mgmt_wdata_i),
    .ib_ready_i,
    .page_q_o(page_q), .cmd_q_o(cmd_q),
    .ib_page_o, .ib_offset_o, .ib_rd_o, .ib_wr_o,
    .load_o(load)
  );

  assign ib_wdata_o = lanes_q;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned DEV_W = 5,
  parameter logic [DEV_W-1:0] DEV_ADDR = 5'd30,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mgmt_req_i,
  input logic [DEV_W-1:0]  mgmt_dev_i,
  input logic              mgmt_ack_o,
  input logic [REG_W-1:0]  mgmt_rdata_o,
  input logic [PAGE_W-1:0] ib_page_o,
  input logic [OFS_W-1:0]  ib_offset_o,
  input logic              ib_rd_o,
  input logic              ib_wr_o,
  input logic              ib_ready_i
);
  // R1
  own_addr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_ack_o |-> ($past(mgmt_req_i) && ($past(mgmt_dev_i) == DEV_ADDR)));
  // R1
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_ack_o |-> (mgmt_rdata_o == '0));
  // R11
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ib_rd_o && ib_wr_o));
  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_wr_o && !ib_ready_i) |=> ib_wr_o);
  // R5
  wr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_wr_o && ib_ready_i) |=> !(ib_wr_o || ib_rd_o));
  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_rd_o && !ib_ready_i) |=> ib_rd_o);
  // R6
  rd_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_rd_o && ib_ready_i) |=> !(ib_wr_o || ib_rd_o));
  // R11
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ib_rd_o || ib_wr_o) && !ib_ready_i) |=> ($stable(ib_page_o) && $stable(ib_offset_o)));
endmodule

bind phy_window_bridge pwb_checker #(
  .DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR), .REG_W(REG_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)
) i_pwb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mgmt_req_i(mgmt_req_i), .mgmt_dev_i(mgmt_dev_i),
  .mgmt_ack_o(mgmt_ack_o), .mgmt_rdata_o(mgmt_rdata_o),
  .ib_page_o(ib_page_o), .ib_offset_o(ib_offset_o),
  .ib_rd_o(ib_rd_o), .ib_wr_o(ib_wr_o), .ib_ready_i(ib_ready_i)
);

// File: tb/test_phy_window_bridge.sv
module test_phy_window_bridge;
  localparam logic [4:0] OWN = 5'd30;
  localparam logic [4:0] A_PAGE = 5'h10, A_CMD = 5'h11, A_D0 = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  dev = '0, rg = '0;
  logic [15:0] wd = '0;
  logic        ack;
  logic [15:0] rdo;
  logic [7:0]  ib_page, ib_ofs;
  logic        ib_rd, ib_wr;
  logic [63:0] ib_wdata;
  logic [63:0] ib_rdata = '0;
  logic        ib_ready = 1'b0;

  int n_chk = 0, n_err = 0;
  int rsp_lat = 0, rsp_cnt = 0;
  int rd_txn = 0, wr_txn = 0;
  logic [63:0] mem [bit [15:0]];

  always #2 clk = ~clk;

  phy_window_bridge i_phy_window_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .mgmt_req_i(req), .mgmt_we_i(we), .mgmt_dev_i(dev), .mgmt_reg_i(rg),
    .mgmt_wdata_i(wd), .mgmt_ack_o(ack), .mgmt_rdata_o(rdo),
    .ib_page_o(ib_page), .ib_offset_o(ib_ofs), .ib_rd_o(ib_rd), .ib_wr_o(ib_wr),
    .ib_wdata_o(ib_wdata), .ib_rdata_i(ib_rdata), .ib_ready_i(ib_ready)
  );

  function automatic logic [63:0] dflt(bit [15:0] k);
    return {k ^ 16'h1111, k ^ 16'h2222, ~k, k};
  endfunction

  function automatic logic [63:0] mem_get(bit [15:0] k);
    return mem.exists(k) ? mem[k] : dflt(k);
  endfunction

  // internal bus responder
  always @(negedge clk) begin
    if (!rst_n) begin
      ib_ready = 1'b0;
      rsp_cnt  = 0;
    end else if (ib_ready) begin
      ib_ready = 1'b0;
    end else if (ib_rd || ib_wr) begin
      if (rsp_cnt >= rsp_lat) begin
        rsp_cnt = 0;
        ib_ready = 1'b1;
        if (ib_rd) begin
          ib_rdata = mem_get({ib_page, ib_ofs});
          rd_txn++;
        end else begin
          mem[{ib_page, ib_ofs}] = ib_wdata;
          wr_txn++;
        end
      end else begin
        rsp_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [4:0] d, input logic [4:0] r, input logic w,
                     input logic [15:0] v, output logic a, output logic [15:0] q);
    @(negedge clk);
    req = 1'b1; we = w; dev = d; rg = r; wd = v;
    @(negedge clk);
    a = ack; q = rdo;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] r, input logic [15:0] v);
    logic a; logic [15:0] q;
    acc(OWN, r, 1'b1, v, a, q);
  endtask

  task automatic rd(input logic [4:0] r, output logic [15:0] q);
    logic a;
    acc(OWN, r, 1'b0, 16'h0, a, q);
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] q;
    int polls = 0;
    do begin
      rd(A_CMD, q);
      polls++;
    end while ((q[1:0] != 2'b00) && polls < 50);
    chk({tag, " busy clears"}, 64'(q[1:0]), 64'd0);
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [15:0] q;
    for (int l = 0; l < 4; l++) begin
      rd(A_D0 + 5'(l), q);
      v[l*16 +: 16] = q;
    end
  endtask

  task automatic wr64(input logic [63:0] v);
    for (int l = 0; l < 4; l++) wr(A_D0 + 5'(l), v[l*16 +: 16]);
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL R3 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [63:0] v, d;
    logic a;
    int rb, wb;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_PAGE, q); chk("R2 reset page", 64'(q), 64'h0);
    rd(A_CMD, q);  chk("R3 reset cmd", 64'(q), 64'h0);
    rd64(v);       chk("R4 reset data", v, 64'h0);
    chk("R5 reset strobes", 64'({ib_rd, ib_wr}), 64'h0);

    // R2 field layout
    wr(A_PAGE, 16'hFFFF); rd(A_PAGE, q); chk("R2 page mask", 64'(q), 64'hFF01);
    wr(A_PAGE, 16'h1201); rd(A_PAGE, q); chk("R2 page set", 64'(q), 64'h1201);

    // R4 lanes
    d = 64'hDEAD_BEEF_0123_4567;
    wr64(d); rd64(v); chk("R4 lanes", v, d);

    // R5 write command, R3 busy then clear
    rsp_lat = 3; wb = wr_txn;
    wr(A_CMD, 16'h3401);
    rd(A_CMD, q); chk("R3 busy wr", 64'(q), 64'h3401);
    wait_idle("R3");
    rd(A_CMD, q); chk("R3 cleared", 64'(q), 64'h3400);
    chk("R5 mem", mem_get(16'h1234), d);
    chk("R5 one write", 64'(wr_txn - wb), 64'd1);

    // R6 read command
    rsp_lat = 1; rb = rd_txn;
    wr(A_CMD, 16'h5602);
    rd(A_CMD, q); chk("R3 busy rd", 64'(q), 64'h5602);
    wait_idle("R6");
    rd64(v); chk("R6 load", v, dflt(16'h1256));
    chk("R6 one read", 64'(rd_txn - rb), 64'd1);
    wr(A_CMD, 16'h3402); wait_idle("R6");
    rd64(v); chk("R6 readback written", v, d);

    // R8 both bits -> read
    rsp_lat = 0; rb = rd_txn; wb = wr_txn;
    wr(A_CMD, 16'h7703); wait_idle("R8");
    rd64(v); chk("R8 data", v, dflt(16'h1277));
    chk("R8 reads", 64'(rd_txn - rb), 64'd1);
    chk("R8 no write", 64'(wr_txn - wb), 64'd0);

    // R7 enable clear
    wr(A_PAGE, 16'h1200); rb = rd_txn; wb = wr_txn;
    wr(A_CMD, 16'h9901);
    rd(A_CMD, q); chk("R7 cmd bits", 64'(q), 64'h9900);
    wr(A_CMD, 16'h9902);
    repeat (8) @(negedge clk);
    chk("R7 no access", 64'((rd_txn - rb) + (wr_txn - wb)), 64'd0);
    chk("R7 no mem", 64'(mem.exists(16'h1299)), 64'd0);
    rd64(v); chk("R7 data kept", v, dflt(16'h1277));

    // R9 other offsets
    wr(5'h05, 16'hAAAA); wr(5'h1C, 16'h5555); wr(5'h12, 16'h1234);
    rd(5'h05, q); chk("R9 off05", 64'(q), 64'h0);
    rd(5'h1C, q); chk("R9 off1C", 64'(q), 64'h0);
    rd(5'h12, q); chk("R9 off12", 64'(q), 64'h0);
    rd(A_PAGE, q); chk("R9 page kept", 64'(q), 64'h1200);
    rd64(v); chk("R9 data kept", v, dflt(16'h1277));

    // R1 other device address
    acc(5'd3, A_PAGE, 1'b1, 16'h7701, a, q); chk("R1 no ack wr", 64'(a), 64'd0);
    acc(5'd3, A_PAGE, 1'b0, 16'h0, a, q);
    chk("R1 no ack rd", 64'(a), 64'd0);
    chk("R1 rdata zero", 64'(q), 64'd0);
    acc(OWN, A_PAGE, 1'b0, 16'h0, a, q);
    chk("R1 own ack", 64'(a), 64'd1);
    chk("R1 page untouched", 64'(q), 64'h1200);

    // R10 write while pending
    wr(A_PAGE, 16'h2101); rsp_lat = 6; rb = rd_txn; wb = wr_txn;
    d = 64'h0F0E_0D0C_0B0A_0908; wr64(d);
    wr(A_CMD, 16'h4401); wr(A_CMD, 16'h5502);
    rd(A_CMD, q); chk("R10 pending kept", 64'(q), 64'h4401);
    wait_idle("R10");
    rd(A_CMD, q); chk("R10 offset kept", 64'(q), 64'h4400);
    chk("R10 mem", mem_get(16'h2144), d);
    chk("R10 no read", 64'(rd_txn - rb), 64'd0);
    chk("R10 no 55", 64'(mem.exists(16'h2155)), 64'd0);

    // constrained random traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] pg, of;
      logic       isrd;
      pg = 8'($urandom_range(0, 3));
      of = 8'($urandom_range(0, 15));
      isrd = 1'($urandom_range(0, 1));
      rsp_lat = $urandom_range(0, 4);
      wr(A_PAGE, {pg, 8'h01});
      if (isrd) begin
        wr(A_CMD, {of, 8'h02}); wait_idle("R6");
        rd64(v); chk("R6 random read", v, mem_get({pg, of}));
      end else begin
        d = {$urandom(), $urandom()};
        wr64(d); wr(A_CMD, {of, 8'h01}); wait_idle("R5");
        chk("R5 random write", mem_get({pg, of}), d);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule